// File: doc/BRIEF.md
# Four-Step Scalar Multiply-Accumulate Sequencer

This block runs a chain of four dependent scalar single-precision fused multiply-add steps into lane 0 of a destination. The multiplier operands come from two places. One is lane 0 of four consecutive vector registers taken from a 4-aligned register block. The other is the four 32-bit elements of a 128-bit memory operand, used in order. The block does no arithmetic of its own. Each step is sent as a request to an external FMA unit over a valid/ready handshake. The rounded result that comes back becomes the accumulator for the next step, so rounding happens once per step.

The block also handles the instruction-level behaviour around the arithmetic. Before it reads memory it checks the writemask, so a masked-off operation makes no memory access and issues no FMA request. It applies zeroing or merging to lane 0 and keeps lanes 1 to 3. It clears everything above the 128-bit vector length. It collects the per-step exception flags. When a step returns an exception that is not masked, the sequence stops at the earliest such step and the destination is not written.

Top module: `quad_fma_sequencer`

## Requirements
- R1: Step j (j = 0..3, in increasing order) sends an FMA request whose register operand is lane 0 of register base+j and whose memory operand is memory bits [32j+31:32j]. A request is held stable until the FMA unit accepts it.
- R2: The register block base is the 5-bit source index with its two low bits cleared. The register read address is {base[4:2], j}.
- R3: The first request carries destination lane 0 as its accumulator. Each later request carries the previous step's returned result. After a completed sequence, lane 0 of the result equals the last returned result. Every request carries the rounding mode captured at start.
- R4: The negate indication on every request equals the negated-form input captured at start (1 = subtract the product, 0 = add it).
- R5: The operation is active when writemask use is off or mask bit 0 is 1. When it is inactive, no FMA request is made and the result lane 0 is 0 if zeroing is selected, or the original lane 0 otherwise. The result is still written.
- R6: An active operation makes exactly one memory request before its first FMA request. An inactive operation makes none.
- R7: The flag encoding is bit0 invalid, bit1 denormal, bit2 overflow, bit3 underflow, bit4 precision. The reported flags are the OR of the flags returned by every step that ran.
- R8: A step whose returned flags include a bit that is clear in the exception mask stops the sequence. The fault indication is raised with that step's index, the destination write enable stays low, and no later step is requested. The earliest faulting step wins.
- R9: Result bits [127:32] equal the original destination bits [127:32], and bits above 127 are 0.
- R10: Done is a one-cycle pulse per operation. Start is accepted only while idle, and a start offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request |
| startReady | output | 1 | High while idle |
| negForm | input | 1 | 1 selects the negated form |
| maskEnable | input | 1 | Writemask in use |
| maskBit0 | input | 1 | Writemask bit 0 |
| zeroing | input | 1 | 1 zeroes lane 0 when masked off |
| srcIndex | input | 5 | Source register index |
| roundMode | input | 2 | Rounding mode forwarded to the FMA unit |
| excMask | input | 5 | Exception mask, 1 = masked |
| destIn | input | 512 | Original destination value |
| regAddr | output | 5 | Register read address |
| regLane0 | input | 32 | Lane 0 of the addressed register |
| memReq | output | 1 | Memory operand request |
| memAck | input | 1 | Memory data valid |
| memData | input | 128 | Memory operand |
| fmaReqValid | output | 1 | FMA request valid |
| fmaReqReady | input | 1 | FMA request accepted |
| fmaAcc | output | 32 | Accumulator operand |
| fmaMulA | output | 32 | Register multiplier operand |
| fmaMulB | output | 32 | Memory multiplier operand |
| fmaReqNeg | output | 1 | Subtract the product |
| fmaRound | output | 2 | Rounding mode |
| fmaRspValid | input | 1 | FMA result valid |
| fmaRspReady | output | 1 | Block waits for a result |
| fmaRspResult | input | 32 | Rounded result |
| fmaRspFlags | input | 5 | Flags raised by the step |
| done | output | 1 | Operation finished (one cycle) |
| destWrite | output | 1 | Result may be written (with done) |
| destOut | output | 512 | Result value |
| faultValid | output | 1 | Unmasked exception stopped the sequence |
| faultStep | output | 2 | Index of the faulting step |
| flagsOut | output | 5 | Accumulated exception flags |

## Verification
A wrong step counter or base latch shows up on the register address and the memory operand of the very next FMA request, one cycle after the step advances. A broken accumulator feedback is invisible at the handshake until the next request. It then shows as a wrong accumulator operand, and in the final lane 0 at done. A wrong mask decision shows up in the first cycle after start: either as a memory request that should never have appeared, or as a missing one. Fault priority errors show up as extra FMA requests after the faulting step and as the wrong step index at done.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;

  localparam int FLAG_W = 5;
  localparam int FLG_INVALID   = 0;
  localparam int FLG_DENORMAL  = 1;
  localparam int FLG_OVERFLOW  = 2;
  localparam int FLG_UNDERFLOW = 3;
  localparam int FLG_PRECISION = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMRD,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } qfs_state_e;

  typedef struct packed {
    logic loadOp;    // capture operands at start
    logic loadMem;   // capture memory operand
    logic loadAcc;   // capture returned result and flags
    logic opActive;  // operation runs its steps
  } qfs_strobe_t;

endpackage

// File: rtl/qfs_ctrl.sv
`timescale 1ns/1ps
module qfs_ctrl
  import qfs_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              maskEnable,
  input  logic              maskBit0,
  output logic              startReady,
  output logic              memReq,
  input  logic              memAck,
  output logic              fmaReqValid,
  input  logic              fmaReqReady,
  output logic              fmaRspReady,
  input  logic              fmaRspValid,
  input  logic              unmaskedExc,
  output qfs_strobe_t       strobe,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic              faultValid,
  output logic [STEP_W-1:0] faultStep
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  qfs_state_e state, stateNext;
  logic       activeReg;
  logic       faultReg;
  logic       startFire;
  logic       rspFire;

  assign startFire = (state == ST_IDLE) && startValid;
  assign rspFire   = (state == ST_WAIT) && fmaRspValid;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startValid) stateNext = (!maskEnable || maskBit0) ? ST_MEMRD : ST_DONE;
      ST_MEMRD: if (memAck) stateNext = ST_ISSUE;
      ST_ISSUE: if (fmaReqReady) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (fmaRspValid) begin
          if (unmaskedExc || step == LAST_STEP) stateNext = ST_DONE;
          else stateNext = ST_ISSUE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      step      <= '0;
      activeReg <= 1'b0;
      faultReg  <= 1'b0;
      faultStep <= '0;
    end else begin
      state <= stateNext;
      if (startFire) begin
        activeReg <= !maskEnable || maskBit0;
        step      <= '0;
        faultReg  <= 1'b0;
        faultStep <= '0;
      end else if (rspFire) begin
        if (unmaskedExc) begin
          faultReg  <= 1'b1;
          faultStep <= step;
        end else if (step != LAST_STEP) begin
          step <= step + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadOp   = startFire;
    strobe.loadMem  = (state == ST_MEMRD) && memAck;
    strobe.loadAcc  = rspFire;
    strobe.opActive = activeReg;
  end

  assign startReady  = (state == ST_IDLE);
  assign memReq      = (state == ST_MEMRD);
  assign fmaReqValid = (state == ST_ISSUE);
  assign fmaRspReady = (state == ST_WAIT);
  assign done        = (state == ST_DONE);
  assign faultValid  = done && faultReg;

endmodule

// File: rtl/qfs_datapath.sv
`timescale 1ns/1ps
module qfs_datapath
  import qfs_pkg::*;
#(
  parameter int DEST_W    = 512,
  parameter int VL        = 128,
  parameter int ELEM_W    = 32,
  parameter int STEPS     = 4,
  parameter int REG_IDX_W = 5,
  parameter int STEP_W    = $clog2(STEPS),
  parameter int BASE_W    = REG_IDX_W - STEP_W,
  parameter int MEM_W     = ELEM_W * STEPS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qfs_strobe_t          strobe,
  input  logic [STEP_W-1:0]    step,
  input  logic [REG_IDX_W-1:0] srcIndex,
  input  logic                 negForm,
  input  logic                 zeroing,
  input  logic [1:0]           roundMode,
  input  logic [FLAG_W-1:0]    excMask,
  input  logic [DEST_W-1:0]    destIn,
  input  logic [MEM_W-1:0]     memData,
  input  logic [ELEM_W-1:0]    regLane0,
  input  logic [ELEM_W-1:0]    fmaRspResult,
  input  logic [FLAG_W-1:0]    fmaRspFlags,
  output logic [REG_IDX_W-1:0] regAddr,
  output logic [ELEM_W-1:0]    fmaAcc,
  output logic [ELEM_W-1:0]    fmaMulA,
  output logic [ELEM_W-1:0]    fmaMulB,
  output logic                 fmaReqNeg,
  output logic [1:0]           fmaRound,
  output logic                 unmaskedExc,
  output logic [DEST_W-1:0]    destOut,
  output logic [FLAG_W-1:0]    flagsOut
);

  logic [BASE_W-1:0] baseReg;
  logic              negReg;
  logic              zeroReg;
  logic [1:0]        roundReg;
  logic [FLAG_W-1:0] excMaskReg;
  logic [VL-1:0]     destReg;
  logic [MEM_W-1:0]  memReg;
  logic [ELEM_W-1:0] accReg;
  logic [FLAG_W-1:0] flagAcc;
  logic [ELEM_W-1:0] memElem [STEPS];
  logic [ELEM_W-1:0] lane0Result;

  for (genvar g = 0; g < STEPS; g++) begin : g_elem
    assign memElem[g] = memReg[g*ELEM_W +: ELEM_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= '0;
      negReg     <= 1'b0;
      zeroReg    <= 1'b0;
      roundReg   <= '0;
      excMaskReg <= '0;
      destReg    <= '0;
      memReg     <= '0;
      accReg     <= '0;
      flagAcc    <= '0;
    end else begin
      if (strobe.loadOp) begin
        baseReg    <= srcIndex[REG_IDX_W-1:STEP_W];
        negReg     <= negForm;
        zeroReg    <= zeroing;
        roundReg   <= roundMode;
        excMaskReg <= excMask;
        destReg    <= destIn[VL-1:0];
        accReg     <= destIn[ELEM_W-1:0];
        flagAcc    <= '0;
      end
      if (strobe.loadMem) memReg <= memData;
      if (strobe.loadAcc) begin
        accReg  <= fmaRspResult;
        flagAcc <= flagAcc | fmaRspFlags;
      end
    end
  end

  assign regAddr     = {baseReg, step};
  assign fmaAcc      = accReg;
  assign fmaMulA     = regLane0;
  assign fmaMulB     = memElem[step];
  assign fmaReqNeg   = negReg;
  assign fmaRound    = roundReg;
  assign unmaskedExc = |(fmaRspFlags & ~excMaskReg);
  assign flagsOut    = flagAcc;

  always_comb begin
    if (strobe.opActive) lane0Result = accReg;
    else if (zeroReg)    lane0Result = '0;
    else                 lane0Result = destReg[ELEM_W-1:0];
  end

  always_comb begin
    destOut               = '0;
    destOut[VL-1:ELEM_W]  = destReg[VL-1:ELEM_W];
    destOut[ELEM_W-1:0]   = lane0Result;
  end

endmodule

// File: rtl/quad_fma_sequencer.sv
`timescale 1ns/1ps
module quad_fma_sequencer
  import qfs_pkg::*;
#(
  parameter int DEST_W    = 512,
  parameter int VL        = 128,
  parameter int ELEM_W    = 32,
  parameter int STEPS     = 4,
  parameter int REG_IDX_W = 5,
  parameter int STEP_W    = $clog2(STEPS),
  parameter int MEM_W     = ELEM_W * STEPS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  output logic                 startReady,
  input  logic                 negForm,
  input  logic                 maskEnable,
  input  logic                 maskBit0,
  input  logic                 zeroing,
  input  logic [REG_IDX_W-1:0] srcIndex,
  input  logic [1:0]           roundMode,
  input  logic [FLAG_W-1:0]    excMask,
  input  logic [DEST_W-1:0]    destIn,
  output logic [REG_IDX_W-1:0] regAddr,
  input  logic [ELEM_W-1:0]    regLane0,
  output logic                 memReq,
  input  logic                 memAck,
  input  logic [MEM_W-1:0]     memData,
  output logic                 fmaReqValid,
  input  logic                 fmaReqReady,
  output logic [ELEM_W-1:0]    fmaAcc,
  output logic [ELEM_W-1:0]    fmaMulA,
  output logic [ELEM_W-1:0]    fmaMulB,
  output logic                 fmaReqNeg,
  output logic [1:0]           fmaRound,
  input  logic                 fmaRspValid,
  output logic                 fmaRspReady,
  input  logic [ELEM_W-1:0]    fmaRspResult,
  input  logic [FLAG_W-1:0]    fmaRspFlags,
  output logic                 done,
  output logic                 destWrite,
  output logic [DEST_W-1:0]    destOut,
  output logic                 faultValid,
  output logic [STEP_W-1:0]    faultStep,
  output logic [FLAG_W-1:0]    flagsOut
);

  qfs_strobe_t       strobe;
  logic [STEP_W-1:0] step;
  logic              unmaskedExc;

  qfs_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .maskEnable  (maskEnable),
    .maskBit0    (maskBit0),
    .startReady  (startReady),
    .memReq      (memReq),
    .memAck      (memAck),
    .fmaReqValid (fmaReqValid),
    .fmaReqReady (fmaReqReady),
    .fmaRspReady (fmaRspReady),
    .fmaRspValid (fmaRspValid),
    .unmaskedExc (unmaskedExc),
    .strobe      (strobe),
    .step        (step),
    .done        (done),
    .faultValid  (faultValid),
    .faultStep   (faultStep)
  );

  qfs_datapath #(
    .DEST_W(DEST_W), .VL(VL), .ELEM_W(ELEM_W), .STEPS(STEPS),
    .REG_IDX_W(REG_IDX_W), .STEP_W(STEP_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .step         (step),
    .srcIndex     (srcIndex),
    .negForm      (negForm),
    .zeroing      (zeroing),
    .roundMode    (roundMode),
    .excMask      (excMask),
    .destIn       (destIn),
    .memData      (memData),
    .regLane0     (regLane0),
    .fmaRspResult (fmaRspResult),
    .fmaRspFlags  (fmaRspFlags),
    .regAddr      (regAddr),
    .fmaAcc       (fmaAcc),
    .fmaMulA      (fmaMulA),
    .fmaMulB      (fmaMulB),
    .fmaReqNeg    (fmaReqNeg),
    .fmaRound     (fmaRound),
    .unmaskedExc  (unmaskedExc),
    .destOut      (destOut),
    .flagsOut     (flagsOut)
  );

  assign destWrite = done && !faultValid;

endmodule

// File: rtl/qfs_checker.sv
`timescale 1ns/1ps
module qfs_checker #(
  parameter int DEST_W    = 512,
  parameter int VL        = 128,
  parameter int ELEM_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int STEP_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 startValid,
  input logic                 startReady,
  input logic                 negForm,
  input logic                 maskEnable,
  input logic                 maskBit0,
  input logic [REG_IDX_W-1:0] srcIndex,
  input logic [REG_IDX_W-1:0] regAddr,
  input logic                 memReq,
  input logic                 fmaReqValid,
  input logic                 fmaReqReady,
  input logic [ELEM_W-1:0]    fmaAcc,
  input logic [ELEM_W-1:0]    fmaMulB,
  input logic                 fmaReqNeg,
  input logic                 fmaRspReady,
  input logic                 done,
  input logic                 destWrite,
  input logic [DEST_W-1:0]    destOut,
  input logic                 faultValid
);

  logic                          expActive;
  logic                          expNeg;
  logic [REG_IDX_W-STEP_W-1:0]   expBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expActive <= 1'b0;
      expNeg    <= 1'b0;
      expBase   <= '0;
    end else if (startValid && startReady) begin
      expActive <= !maskEnable || maskBit0;
      expNeg    <= negForm;
      expBase   <= srcIndex[REG_IDX_W-1:STEP_W];
    end
  end

  a_r6_mem_only_active: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> expActive);

  a_r5_no_fma_inactive: assert property (@(posedge clk) disable iff (!rstN)
    fmaReqValid |-> expActive);

  a_r2_block_base: assert property (@(posedge clk) disable iff (!rstN)
    fmaReqValid |-> regAddr[REG_IDX_W-1:STEP_W] == expBase);

  a_r4_neg_forward: assert property (@(posedge clk) disable iff (!rstN)
    fmaReqValid |-> fmaReqNeg == expNeg);

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fmaReqValid && !fmaReqReady) |=> (fmaReqValid && $stable(regAddr) &&
                                       $stable(fmaAcc) && $stable(fmaMulB)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || fmaReqValid || fmaRspReady || done) |-> !startReady);

  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (done && !destWrite));

  if (DEST_W > VL) begin : g_upper
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
      done |-> destOut[DEST_W-1:VL] == '0);
  end

endmodule

bind quad_fma_sequencer qfs_checker #(
  .DEST_W(DEST_W), .VL(VL), .ELEM_W(ELEM_W), .REG_IDX_W(REG_IDX_W), .STEP_W(STEP_W)
) u_qfs_checker (
  .clk         (clk),
  .rstN        (rstN),
  .startValid  (startValid),
  .startReady  (startReady),
  .negForm     (negForm),
  .maskEnable  (maskEnable),
  .maskBit0    (maskBit0),
  .srcIndex    (srcIndex),
  .regAddr     (regAddr),
  .memReq      (memReq),
  .fmaReqValid (fmaReqValid),
  .fmaReqReady (fmaReqReady),
  .fmaAcc      (fmaAcc),
  .fmaMulB     (fmaMulB),
  .fmaReqNeg   (fmaReqNeg),
  .fmaRspReady (fmaRspReady),
  .done        (done),
  .destWrite   (destWrite),
  .destOut     (destOut),
  .faultValid  (faultValid)
);

// File: tb/quad_fma_sequencer_bench.sv
`timescale 1ns/1ps
module quad_fma_sequencer_bench;

  localparam int DEST_W = 512;
  localparam int VL     = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic         startValid = 0, negForm = 0, maskEnable = 0, maskBit0 = 0, zeroing = 0;
  logic [4:0]   srcIndex = 0;
  logic [1:0]   roundMode = 0;
  logic [4:0]   excMask = 5'h1f;
  logic [511:0] destIn = '0;
  logic [127:0] memData = '0;
  logic         startReady, memReq, fmaReqValid, fmaReqNeg, fmaRspReady;
  logic         done, destWrite, faultValid;
  logic [4:0]   regAddr, flagsOut;
  logic [31:0]  regLane0, fmaAcc, fmaMulA, fmaMulB;
  logic [1:0]   fmaRound, faultStep;
  logic [511:0] destOut;
  logic         memAck = 1'b0;
  logic         fmaReqReady;
  logic         fmaRspValid = 1'b0;
  logic [31:0]  fmaRspResult = '0;
  logic [4:0]   fmaRspFlags = '0;

  quad_fma_sequencer u_quad_fma_sequencer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .negForm(negForm), .maskEnable(maskEnable), .maskBit0(maskBit0), .zeroing(zeroing),
    .srcIndex(srcIndex), .roundMode(roundMode), .excMask(excMask), .destIn(destIn),
    .regAddr(regAddr), .regLane0(regLane0), .memReq(memReq), .memAck(memAck),
    .memData(memData), .fmaReqValid(fmaReqValid), .fmaReqReady(fmaReqReady),
    .fmaAcc(fmaAcc), .fmaMulA(fmaMulA), .fmaMulB(fmaMulB), .fmaReqNeg(fmaReqNeg),
    .fmaRound(fmaRound), .fmaRspValid(fmaRspValid), .fmaRspReady(fmaRspReady),
    .fmaRspResult(fmaRspResult), .fmaRspFlags(fmaRspFlags), .done(done),
    .destWrite(destWrite), .destOut(destOut), .faultValid(faultValid),
    .faultStep(faultStep), .flagsOut(flagsOut)
  );

  // register file model: lane 0 of each register
  logic [31:0] regFile [32];
  initial for (int i = 0; i < 32; i++) regFile[i] = 32'h40 + 32'(i) * 7;
  assign regLane0 = regFile[regAddr];

  // FMA unit stub: integer multiply-add, result two cycles after acceptance
  int          reqCount = 0;
  int          opBase = 0;
  int          pendCnt = 0;
  logic        readyTog = 1'b0;
  logic [31:0] pendRes = '0;
  logic [4:0]  pendFlags = '0;
  logic [31:0] logA [8], logB [8], logAcc [8];
  logic        logNeg [8];
  logic [1:0]  logRnd [8];
  logic [4:0]  stepFlags [4];
  int          idx;
  assign fmaReqReady = readyTog;

  always @(posedge clk) begin
    readyTog    <= ~readyTog;
    fmaRspValid <= 1'b0;
    if (pendCnt == 1) begin
      fmaRspValid  <= 1'b1;
      fmaRspResult <= pendRes;
      fmaRspFlags  <= pendFlags;
    end
    if (pendCnt > 0) pendCnt <= pendCnt - 1;
    if (fmaReqValid && fmaReqReady) begin
      idx = reqCount - opBase;
      if (idx >= 0 && idx < 8) begin
        logA[idx] <= fmaMulA; logB[idx] <= fmaMulB; logAcc[idx] <= fmaAcc;
        logNeg[idx] <= fmaReqNeg; logRnd[idx] <= fmaRound;
      end
      pendRes   <= fmaReqNeg ? fmaAcc - fmaMulA * fmaMulB : fmaAcc + fmaMulA * fmaMulB;
      pendFlags <= (idx >= 0 && idx < 4) ? stepFlags[idx] : 5'h0;
      pendCnt   <= 2;
      reqCount  <= reqCount + 1;
    end
  end

  // memory stub
  int memCount = 0;
  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && memAck) memCount <= memCount + 1;
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // captured results of the last operation
  logic [511:0] gotDest;
  logic         gotWrite, gotFault;
  logic [1:0]   gotStep;
  logic [4:0]   gotFlags;
  int           gotReqs, gotMem;

  task automatic runOp(input logic [4:0] src, input logic neg, input logic mEn, input logic mB0,
                       input logic zero, input logic [1:0] rnd, input logic [4:0] exm,
                       input logic [511:0] dest, input logic [127:0] mem, input bit busyPoke);
    int t = 0;
    int memBase;
    @(negedge clk);
    opBase = reqCount; memBase = memCount;
    srcIndex = src; negForm = neg; maskEnable = mEn; maskBit0 = mB0; zeroing = zero;
    roundMode = rnd; excMask = exm; destIn = dest; memData = mem;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    if (busyPoke) begin
      check(!startReady, "R10 not ready while busy", 512'(startReady), 512'd0);
      srcIndex = 5'd0; negForm = ~neg; destIn = '0; maskEnable = 1'b0;
      startValid = 1'b1;
      repeat (4) @(negedge clk);
      startValid = 1'b0;
      srcIndex = src; negForm = neg; destIn = dest; maskEnable = mEn;
    end
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R10 done reached", 512'(done), 512'd1);
    gotDest = destOut; gotWrite = destWrite; gotFault = faultValid;
    gotStep = faultStep; gotFlags = flagsOut;
    gotReqs = reqCount - opBase; gotMem = memCount - memBase;
    @(negedge clk);
    check(!done, "R10 done lasts one cycle", 512'(done), 512'd0);
  endtask

  function automatic logic [31:0] chainModel(input logic [31:0] acc0, input int base,
                                             input logic neg, input logic [127:0] mem, input int n);
    logic [31:0] a = acc0;
    for (int j = 0; j < n; j++) begin
      if (neg) a = a - regFile[base + j] * mem[32*j +: 32];
      else     a = a + regFile[base + j] * mem[32*j +: 32];
    end
    return a;
  endfunction

  function automatic logic [511:0] expDest(input logic [511:0] dest, input logic [31:0] lane0);
    logic [511:0] e = '0;
    e[127:32] = dest[127:32];
    e[31:0]   = lane0;
    return e;
  endfunction

  localparam logic [511:0] DEST_A = {384'hDEAD_BEEF_0123_4567_89AB_CDEF, 128'h1111_2222_3333_4444_5555_6666_7777_8888};
  localparam logic [127:0] MEM_A  = 128'h0000_0009_0000_0005_0000_0003_0000_0002;
  localparam logic [127:0] MEM_B  = 128'h0000_0100_0000_0011_0000_0021_0000_0007;

  task automatic testReset();
    check(startReady && !done && !memReq && !fmaReqValid, "R10 reset idle",
          {508'd0, startReady, done, memReq, fmaReqValid}, 512'h8);
  endtask

  task automatic testBasic();
    for (int j = 0; j < 4; j++) stepFlags[j] = 5'h0;
    runOp(5'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 5'h1f, DEST_A, MEM_A, 1'b0);
    check(gotReqs == 4, "R1 four steps", 512'(gotReqs), 512'd4);
    for (int j = 0; j < 4; j++) begin
      check(logA[j] == regFile[4 + j], "R2 register block base+j", 512'(logA[j]), 512'(regFile[4 + j]));
      check(logB[j] == MEM_A[32*j +: 32], "R1 memory element j", 512'(logB[j]), 512'(MEM_A[32*j +: 32]));
      check(logAcc[j] == chainModel(DEST_A[31:0], 4, 1'b0, MEM_A, j), "R3 accumulator chain",
            512'(logAcc[j]), 512'(chainModel(DEST_A[31:0], 4, 1'b0, MEM_A, j)));
      check(logRnd[j] == 2'd2, "R3 rounding mode forwarded", 512'(logRnd[j]), 512'd2);
      check(logNeg[j] == 1'b0, "R4 add form", 512'(logNeg[j]), 512'd0);
    end
    check(gotMem == 1, "R6 one memory request", 512'(gotMem), 512'd1);
    check(gotDest == expDest(DEST_A, chainModel(DEST_A[31:0], 4, 1'b0, MEM_A, 4)),
          "R9 R3 result and upper clear", gotDest, expDest(DEST_A, chainModel(DEST_A[31:0], 4, 1'b0, MEM_A, 4)));
    check(gotWrite && !gotFault && gotFlags == 0, "R7 clean completion",
          {505'd0, gotWrite, gotFault, gotFlags}, 512'h40);
  endtask

  task automatic testNeg();
    runOp(5'd31, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 5'h1f, DEST_A, MEM_B, 1'b0);
    check(logA[0] == regFile[28] && logA[3] == regFile[31], "R2 base of index 31",
          512'(logA[0]), 512'(regFile[28]));
    check(logNeg[0] && logNeg[3], "R4 negated form forwarded", 512'(logNeg[3]), 512'd1);
    check(gotDest[31:0] == chainModel(DEST_A[31:0], 28, 1'b1, MEM_B, 4), "R4 subtract chain",
          512'(gotDest[31:0]), 512'(chainModel(DEST_A[31:0], 28, 1'b1, MEM_B, 4)));
    check(gotMem == 1 && gotReqs == 4, "R5 mask bit set runs", 512'(gotReqs), 512'd4);
  endtask

  task automatic testMerge();
    runOp(5'd9, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 5'h1f, DEST_A, MEM_A, 1'b0);
    check(gotMem == 0, "R6 no memory request when masked", 512'(gotMem), 512'd0);
    check(gotReqs == 0, "R5 no FMA when masked", 512'(gotReqs), 512'd0);
    check(gotWrite && gotDest == expDest(DEST_A, DEST_A[31:0]), "R5 merge keeps lane 0",
          gotDest, expDest(DEST_A, DEST_A[31:0]));
  endtask

  task automatic testZero();
    runOp(5'd9, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 5'h1f, DEST_A, MEM_A, 1'b0);
    check(gotMem == 0 && gotReqs == 0, "R6 zeroing makes no access", 512'(gotReqs + gotMem), 512'd0);
    check(gotWrite && gotDest == expDest(DEST_A, 32'h0), "R5 zeroing clears lane 0",
          gotDest, expDest(DEST_A, 32'h0));
  endtask

  task automatic testMaskedFlags();
    stepFlags[0] = 5'b10000; stepFlags[1] = 5'b00000;
    stepFlags[2] = 5'b01000; stepFlags[3] = 5'b00010;
    runOp(5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 5'h1f, DEST_A, MEM_B, 1'b0);
    check(gotFlags == 5'b11010, "R7 flags OR-accumulated", 512'(gotFlags), 512'h1a);
    check(!gotFault && gotWrite && gotReqs == 4, "R7 masked flags do not stop",
          512'(gotReqs), 512'd4);
  endtask

  task automatic testFault();
    stepFlags[0] = 5'b10000; stepFlags[1] = 5'b00100;
    stepFlags[2] = 5'b00000; stepFlags[3] = 5'b00100;
    runOp(5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'b11011, DEST_A, MEM_A, 1'b0);
    check(gotFault && gotStep == 2'd1, "R8 earliest faulting step", 512'(gotStep), 512'd1);
    check(!gotWrite, "R8 no write on fault", 512'(gotWrite), 512'd0);
    check(gotReqs == 2, "R8 no later step requested", 512'(gotReqs), 512'd2);
    check(gotFlags == 5'b10100, "R7 flags up to fault", 512'(gotFlags), 512'h14);
    stepFlags[0] = 5'b00001; stepFlags[1] = 5'b0; stepFlags[2] = 5'b0; stepFlags[3] = 5'b0;
    runOp(5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 5'b11110, DEST_A, MEM_A, 1'b0);
    check(gotFault && gotStep == 2'd0 && gotReqs == 1, "R8 fault at step 0",
          512'(gotReqs), 512'd1);
  endtask

  task automatic testBusy();
    for (int j = 0; j < 4; j++) stepFlags[j] = 5'h0;
    runOp(5'd21, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 5'h1f, DEST_A, MEM_B, 1'b1);
    check(gotReqs == 4, "R10 start while busy ignored", 512'(gotReqs), 512'd4);
    check(gotDest[31:0] == chainModel(DEST_A[31:0], 20, 1'b0, MEM_B, 4), "R10 result unaffected",
          512'(gotDest[31:0]), 512'(chainModel(DEST_A[31:0], 20, 1'b0, MEM_B, 4)));
    repeat (10) @(negedge clk);
    check(reqCount - opBase == 4 && !done, "R10 no second operation", 512'(reqCount - opBase), 512'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testNeg();
    testMerge();
    testZero();
    testMaskedFlags();
    testFault();
    testBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule